// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder

This block is the combinational decode stage of a small load/store processor that runs one instruction per clock. It takes the 16-bit instruction word that was fetched in the current cycle. From it, the block produces the control word for the datapath: the register-file write enable, the three register addresses, the operand-B source, the ALU function, the data-memory write enable and the writeback source. It also produces the information the branch unit needs, which is whether the instruction is a jump or a conditional branch, which of eight conditions applies, and the 6-bit target field.

The opcode sits in bits 15:9. Its upper three bits (15:13) give the category. Its lower four bits (12:9) are a sub-field whose meaning depends on the category:

- For ALU instructions the sub-field is the ALU function.
- For branches its lower three bits (11:9) name the condition.

The register, immediate and jump/branch formats all share one field grid. Because of that, most outputs are plain wires from fixed bit positions, and only a few bits depend on the category.

Category codes are as follows:

| Code | Category |
|------|----------|
| 000 | ALU with two registers |
| 001 | ALU with a constant |
| 010 | load |
| 011 | store |
| 100 | branch |
| 101 | jump |
| 110 | no-op |
| 111 | no-op |

Top module: `instr_decoder`

## Requirements
- R1: The destination address is always bits 8:6 and the B source address is always bits 2:0. The A source address is bits 8:6 for branch (100) and jump (101) and bits 5:3 for every other category.
- R2: For categories 000 and 001 the ALU function equals bits 12:9. For every other category it is 0000.
- R3: The operand-B select is 1 (use the constant) only for category 001. Otherwise it is 0 (use the register).
- R4: The constant output is bits 2:0 zero-extended to DATA_W bits. The target output is bits 5:0. Both hold for every category.
- R5: Register write is 1 for categories 000, 001 and 010 only.
- R6: Memory write is 1 for category 011 only.
- R7: The writeback select is 1 (data memory) for category 010 only. Otherwise it is 0 (ALU result).
- R8: The branch flag is 1 for category 100 only. The condition output is then bits 11:9, and bit 12 has no effect on it. For all other categories the condition output is 000.
- R9: The jump flag is 1 for category 101 only.
- R10: Categories 110 and 111 assert no write enable, no operand-B constant select, no memory writeback select and no jump or branch flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Fetched instruction word |
| rf_we_o | output | 1 | Register-file write enable |
| rf_dst_o | output | 3 | Destination register address |
| rf_srca_o | output | 3 | A-port source register address |
| rf_srcb_o | output | 3 | B-port source register address |
| opb_const_o | output | 1 | 1: operand B is the constant; 0: register B |
| alu_fn_o | output | 4 | ALU function select |
| mem_we_o | output | 1 | Data-memory write enable |
| wb_mem_o | output | 1 | 1: write back memory data; 0: ALU result |
| const_o | output | DATA_W | Zero-extended 3-bit constant |
| is_branch_o | output | 1 | Conditional branch flag |
| is_jump_o | output | 1 | Jump flag |
| br_cond_o | output | 3 | Branch condition index |
| br_target_o | output | 6 | Jump or branch address field |

## Verification
The assertions assume only that the instruction input is a settled 16-bit value. Every code, including the two spare categories, has a defined decode, so the assertions put no constraint on the encoding. They check the cross-output rules that must hold for any word: the exclusive enables, the single control-flow flag, memory writeback only with a register write, and a nonzero condition only on a branch. The random stimulus draws the full 16-bit space, so every category and sub-field value appears. Directed words add one instruction of each category, both spare codes, and a branch with bit 12 set.

// File: rtl/instr_decoder.sv
module instr_decoder #(
  parameter int DATA_W = 16
) (
  input  logic [15:0]       instr_i,
  output logic              rf_we_o,
  output logic [2:0]        rf_dst_o,
  output logic [2:0]        rf_srca_o,
  output logic [2:0]        rf_srcb_o,
  output logic              opb_const_o,
  output logic [3:0]        alu_fn_o,
  output logic              mem_we_o,
  output logic              wb_mem_o,
  output logic [DATA_W-1:0] const_o,
  output logic              is_branch_o,
  output logic              is_jump_o,
  output logic [2:0]        br_cond_o,
  output logic [5:0]        br_target_o
);
  localparam logic [2:0] CAT_ALU_R = 3'b000;
  localparam logic [2:0] CAT_ALU_I = 3'b001;
  localparam logic [2:0] CAT_LOAD  = 3'b010;
  localparam logic [2:0] CAT_STORE = 3'b011;
  localparam logic [2:0] CAT_BR    = 3'b100;
  localparam logic [2:0] CAT_JMP   = 3'b101;
  localparam int         PAD_W     = DATA_W - 3;

  logic [2:0] cat;
  logic [3:0] sub;
  logic       alu_cat, flow_cat;

  assign cat      = instr_i[15:13];
  assign sub      = instr_i[12:9];
  assign alu_cat  = (cat == CAT_ALU_R) || (cat == CAT_ALU_I);
  assign flow_cat = (cat == CAT_BR) || (cat == CAT_JMP);

  assign rf_dst_o    = instr_i[8:6];
  assign rf_srca_o   = flow_cat ? instr_i[8:6] : instr_i[5:3];
  assign rf_srcb_o   = instr_i[2:0];
  assign const_o     = {{PAD_W{1'b0}}, instr_i[2:0]};
  assign br_target_o = instr_i[5:0];

  assign alu_fn_o    = alu_cat ? sub : 4'b0000;
  assign opb_const_o = (cat == CAT_ALU_I);
  assign rf_we_o     = alu_cat || (cat == CAT_LOAD);
  assign mem_we_o    = (cat == CAT_STORE);
  assign wb_mem_o    = (cat == CAT_LOAD);
  assign is_branch_o = (cat == CAT_BR);
  assign is_jump_o   = (cat == CAT_JMP);
  assign br_cond_o   = is_branch_o ? sub[2:0] : 3'b000;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk #(
  parameter int DATA_W = 16
) (
  input logic [15:0]       instr_i,
  input logic              rf_we_o,
  input logic [2:0]        rf_dst_o,
  input logic [2:0]        rf_srca_o,
  input logic [2:0]        rf_srcb_o,
  input logic              opb_const_o,
  input logic [3:0]        alu_fn_o,
  input logic              mem_we_o,
  input logic              wb_mem_o,
  input logic [DATA_W-1:0] const_o,
  input logic              is_branch_o,
  input logic              is_jump_o,
  input logic [2:0]        br_cond_o,
  input logic [5:0]        br_target_o
);
  always_comb begin
    // R5
    we_excl_chk: assert (!(rf_we_o && mem_we_o)) else $error("register and memory write together");
    // R9
    flow_onehot_chk: assert ($onehot0({is_branch_o, is_jump_o})) else $error("jump and branch together");
    // R7
    wb_needs_we_chk: assert (!wb_mem_o || rf_we_o) else $error("memory writeback without register write");
    // R3
    const_needs_we_chk: assert (!opb_const_o || rf_we_o) else $error("constant operand without register write");
    // R8
    cond_only_branch_chk: assert (br_cond_o == 3'b000 || is_branch_o) else $error("condition outside branch");
    // R8
    branch_no_write_chk: assert (!is_branch_o || (!rf_we_o && !mem_we_o)) else $error("branch writes state");
    // R2
    fn_needs_we_chk: assert (alu_fn_o == 4'b0000 || rf_we_o) else $error("ALU function without register write");
  end
endmodule

bind instr_decoder instr_decoder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_instr_decoder.sv
module tb_instr_decoder;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0]       instr;
  logic              rf_we, opb_const, mem_we, wb_mem, is_branch, is_jump;
  logic [2:0]        rf_dst, rf_srca, rf_srcb, br_cond;
  logic [3:0]        alu_fn;
  logic [DATA_W-1:0] konst;
  logic [5:0]        br_target;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  instr_decoder #(.DATA_W(DATA_W)) dut (
    .instr_i(instr), .rf_we_o(rf_we), .rf_dst_o(rf_dst), .rf_srca_o(rf_srca),
    .rf_srcb_o(rf_srcb), .opb_const_o(opb_const), .alu_fn_o(alu_fn),
    .mem_we_o(mem_we), .wb_mem_o(wb_mem), .const_o(konst),
    .is_branch_o(is_branch), .is_jump_o(is_jump), .br_cond_o(br_cond),
    .br_target_o(br_target)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input logic [15:0] w);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s instr=%h actual=%h expected=%h", req, w, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    logic [2:0] c;
    c = w[15:13];
    @(posedge clk);
    instr = w;
    @(negedge clk);
    chk("R1 dst",  32'(rf_dst),  32'(w[8:6]), w);
    chk("R1 srca", 32'(rf_srca), (c == 3'b100 || c == 3'b101) ? 32'(w[8:6]) : 32'(w[5:3]), w);
    chk("R1 srcb", 32'(rf_srcb), 32'(w[2:0]), w);
    chk("R2 alu_fn", 32'(alu_fn), (c <= 3'b001) ? 32'(w[12:9]) : 32'd0, w);
    chk("R3 opb_const", 32'(opb_const), 32'(c == 3'b001), w);
    chk("R4 const", 32'(konst), 32'(w[2:0]), w);
    chk("R4 target", 32'(br_target), 32'(w[5:0]), w);
    chk("R5 rf_we", 32'(rf_we), 32'(c <= 3'b010), w);
    chk("R6 mem_we", 32'(mem_we), 32'(c == 3'b011), w);
    chk("R7 wb_mem", 32'(wb_mem), 32'(c == 3'b010), w);
    chk("R8 is_branch", 32'(is_branch), 32'(c == 3'b100), w);
    chk("R8 cond", 32'(br_cond), (c == 3'b100) ? 32'(w[11:9]) : 32'd0, w);
    chk("R9 is_jump", 32'(is_jump), 32'(c == 3'b101), w);
    if (c[2:1] == 2'b11)
      chk("R10 spare quiet",
          32'({rf_we, mem_we, wb_mem, opb_const, is_branch, is_jump}), 32'd0, w);
  endtask

  initial begin
    instr = 16'h0000;
    void'($urandom(32'd20240611));
    // one of each category, then corners
    apply(16'b000_0101_001_010_011);   // R2 ALU register
    apply(16'b001_1100_111_000_101);   // R3 ALU immediate
    apply(16'b010_0000_100_110_000);   // R7 load
    apply(16'b011_0000_000_101_110);   // R6 store
    apply(16'b100_0011_010_101_010);   // R8 branch
    apply(16'b100_1011_010_101_010);   // R8 bit 12 ignored
    apply(16'b101_0000_000_010_010);   // R9 jump
    apply(16'b110_1111_111_111_111);   // R10
    apply(16'b111_1010_101_010_101);   // R10
    apply(16'hFFFF);
    apply(16'h0000);
    for (int i = 0; i < 400; i++) apply(16'($urandom));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule